// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between four external interrupt request pins and a processor interrupt controller. Every pin is first brought into the clock domain through a chain of synchronizer flops. It is then judged by its own two-bit sense mode: high level, low level, rising edge or falling edge. In the two edge modes a sticky latch records each detected edge until software clears it.

Each line's request is qualified by a per-line enable and by a master enable that covers all lines. The qualified request lines go to the downstream priority logic. A single control word configures the block through a simple write strobe and a read bus that is always valid. The same word carries a routing bit for the critical interrupt, which the block passes straight out. The read bus also shows the edge latches, so that software can see which edges are pending.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset, every control field is 0, every edge latch is 0, `rd_data` reads 0, `irq_req` is 0 and `crit_route` is 0.
- R2: A write (`wr_en` high at a clock edge) updates these fields from `wr_data`: line n's enable at bit 11-n, the master enable at bit 12, line n's two-bit sense code at bits [22-2n+1:22-2n] and the critical routing bit at bit 0. From the next cycle these fields read back at the same positions. Bits 15:13, 7:1 and 27:24 read 0.
- R3: The clear bits 27:24 always read back as 0.
- R4: Sense code 0 (high level) makes line n's request follow the synchronized pin without latching. With the default two synchronizer stages, a pin change shows at `irq_req` after the second rising clock edge, and not after the first.
- R5: Sense code 3 (low level) makes line n's request the inverse of the synchronized pin.
- R6: Sense code 1 (rising edge) sets line n's latch on a 0-to-1 transition. The latch stays set after the pin falls again, and a falling transition does not set it.
- R7: Sense code 2 (falling edge) sets line n's latch on a 1-to-0 transition, and a rising transition does not set it.
- R8: A write with bit 27-n at 1 clears line n's latch. Latches whose clear bit is 0 in the same write keep their state.
- R9: When a clear of line n falls in the same cycle as a newly detected edge on line n, the latch ends up set.
- R10: Line n's request is 0 while its enable is 0, but its latch still records edges. The latch state is visible at `rd_data` bit 28+n.
- R11: While the master enable is 0, all requests are 0 and the latches keep their state.
- R12: `crit_route` carries the stored critical routing bit.
- R13: A line in a level mode never sets its latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| irq_pin | input | 4 | Asynchronous external request pins, line n at bit n |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word readback plus edge latch status in bits 31:28 |
| irq_req | output | 4 | Qualified request lines, line n at bit n |
| crit_route | output | 1 | Stored critical interrupt routing selection |

## Verification
The collision that matters is a write-one clear landing in the same cycle as a fresh edge on the same line. The bench raises a pin and counts the two synchronizer edges. It then times the clear write so that it is sampled on exactly the edge where the edge detector fires. It judges the result through the status bit, which must stay set, and then checks that an isolated clear still empties the latch. The second overlap is a configuration write that changes enables while latches hold state. Here the bench checks that the requests change but the status does not.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   typedef enum logic [1:0] {
      SENSE_LVL_HI = 2'd0,
      SENSE_RISE   = 2'd1,
      SENSE_FALL   = 2'd2,
      SENSE_LVL_LO = 2'd3
   } sense_e;

   localparam int MAX_LINES  = 4;
   localparam int REG_W      = 32;
   localparam int BIT_MASTER = 12;
   localparam int BIT_CRIT   = 0;

   // enable for line n
   function automatic int en_bit(input int n);
      return 11 - n;
   endfunction

   // write-one clear for line n
   function automatic int clr_bit(input int n);
      return 27 - n;
   endfunction

   // low bit of the two-bit sense field of line n
   function automatic int sense_lsb(input int n);
      return 22 - 2 * n;
   endfunction

   // read-only latch status of line n
   function automatic int stat_bit(input int n);
      return 28 + n;
   endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int STAGES = 2,
   parameter int W      = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import ext_irq_pkg::*;
#(
   parameter int N_LINES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wr_data,
   output logic [N_LINES-1:0] line_en,
   output logic               master_en,
   output logic               crit_sel,
   output sense_e             sense [N_LINES],
   output logic [N_LINES-1:0] clr_pulse
);

   logic [N_LINES-1:0] en_q;
   logic [1:0]         sense_q [N_LINES];
   logic               master_q;
   logic               crit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         master_q <= 1'b0;
         crit_q   <= 1'b0;
         for (int n = 0; n < N_LINES; n++) sense_q[n] <= 2'd0;
      end else if (wr_en) begin
         master_q <= wr_data[BIT_MASTER];
         crit_q   <= wr_data[BIT_CRIT];
         for (int n = 0; n < N_LINES; n++) begin
            en_q[n]    <= wr_data[en_bit(n)];
            sense_q[n] <= wr_data[sense_lsb(n) +: 2];
         end
      end
   end

   // clears act only in the write cycle and are never stored
   always_comb begin
      for (int n = 0; n < N_LINES; n++) begin
         clr_pulse[n] = wr_en & wr_data[clr_bit(n)];
         sense[n]     = sense_e'(sense_q[n]);
      end
   end

   assign line_en   = en_q;
   assign master_en = master_q;
   assign crit_sel  = crit_q;

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
   import ext_irq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pin_s,
   input  sense_e sense,
   input  logic   clr,
   input  logic   line_en,
   input  logic   master_en,
   output logic   req,
   output logic   latched
);

   logic prev_q;
   logic latch_q;
   logic rise;
   logic fall;
   logic hit;
   logic active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_s;
   end

   assign rise = pin_s & ~prev_q;
   assign fall = ~pin_s & prev_q;

   always_comb begin
      unique case (sense)
         SENSE_RISE: hit = rise;
         SENSE_FALL: hit = fall;
         default:    hit = 1'b0;
      endcase
   end

   // a new edge overrides a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   latch_q <= 1'b0;
      else if (hit) latch_q <= 1'b1;
      else if (clr) latch_q <= 1'b0;
   end

   always_comb begin
      unique case (sense)
         SENSE_LVL_HI: active = pin_s;
         SENSE_LVL_LO: active = ~pin_s;
         default:      active = latch_q;
      endcase
   end

   assign req     = active & line_en & master_en;
   assign latched = latch_q;

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
   import ext_irq_pkg::*;
#(
   parameter int NUM_LINES   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_pin,
   input  logic                 wr_en,
   input  logic [REG_W-1:0]     wr_data,
   output logic [REG_W-1:0]     rd_data,
   output logic [NUM_LINES-1:0] irq_req,
   output logic                 crit_route
);

   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      $error("ext_irq_unit: NUM_LINES must lie in 1..%0d", MAX_LINES);
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ext_irq_unit: SYNC_STAGES must be at least 2");
   end

   logic [NUM_LINES-1:0] pin_s;
   logic [NUM_LINES-1:0] line_en;
   logic [NUM_LINES-1:0] clr_pulse;
   logic [NUM_LINES-1:0] latched;
   logic                 master_en;
   logic                 crit_sel;
   sense_e               sense [NUM_LINES];

   ext_irq_sync #(
      .STAGES (SYNC_STAGES),
      .W      (NUM_LINES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_pin),
      .q     (pin_s)
   );

   ext_irq_ctrl #(
      .N_LINES (NUM_LINES)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .line_en   (line_en),
      .master_en (master_en),
      .crit_sel  (crit_sel),
      .sense     (sense),
      .clr_pulse (clr_pulse)
   );

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      ext_irq_line u_line (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_s     (pin_s[n]),
         .sense     (sense[n]),
         .clr       (clr_pulse[n]),
         .line_en   (line_en[n]),
         .master_en (master_en),
         .req       (irq_req[n]),
         .latched   (latched[n])
      );
   end

   always_comb begin
      rd_data             = '0;
      rd_data[BIT_MASTER] = master_en;
      rd_data[BIT_CRIT]   = crit_sel;
      for (int n = 0; n < NUM_LINES; n++) begin
         rd_data[en_bit(n)]          = line_en[n];
         rd_data[sense_lsb(n) +: 2]  = sense[n];
         rd_data[stat_bit(n)]        = latched[n];
      end
   end

   assign crit_route = crit_sel;

endmodule

// File: rtl/ext_irq_unit_chk.sv
module ext_irq_unit_chk
   import ext_irq_pkg::*;
#(
   parameter int N_LINES = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [REG_W-1:0]   wr_data,
   input logic [REG_W-1:0]   rd_data,
   input logic [N_LINES-1:0] irq_req,
   input logic               crit_route
);

   AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[BIT_MASTER] |-> (irq_req == '0)); // R11

   AST_CRIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (crit_route == $past(wr_data[BIT_CRIT]))); // R12

   for (genvar n = 0; n < N_LINES; n++) begin : g_ln
      AST_LINE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_data[en_bit(n)] |-> !irq_req[n]); // R10

      AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_data[clr_bit(n)]); // R3

      AST_SENSE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |=> (rd_data[sense_lsb(n) +: 2] == $past(wr_data[sense_lsb(n) +: 2]))); // R2

      AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_data[stat_bit(n)] && !wr_en) |=> rd_data[stat_bit(n)]); // R6

      AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
         ((rd_data[sense_lsb(n) +: 2] == 2'd0 || rd_data[sense_lsb(n) +: 2] == 2'd3)
          && !rd_data[stat_bit(n)] && !wr_en) |=> !rd_data[stat_bit(n)]); // R13
   end

   logic unused_chk_bits;
   assign unused_chk_bits = ^wr_data;

endmodule

bind ext_irq_unit ext_irq_unit_chk #(.N_LINES(NUM_LINES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .rd_data    (rd_data),
   .irq_req    (irq_req),
   .crit_route (crit_route)
);

// File: tb/ext_irq_unit_bench.sv
module ext_irq_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  irq_pin = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [3:0]  irq_req;
   logic        crit_route;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   ext_irq_unit u_ext_irq_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_pin    (irq_pin),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .irq_req    (irq_req),
      .crit_route (crit_route)
   );

   // sense codes: 0 level high, 1 rising, 2 falling, 3 level low
   function automatic logic [31:0] mk(input logic [3:0] en, input logic master,
                                      input logic [7:0] sns, input logic [3:0] clr,
                                      input logic crit);
      logic [31:0] w = '0;
      for (int n = 0; n < 4; n++) begin
         w[11-n]          = en[n];
         w[27-n]          = clr[n];
         w[22-2*n +: 2]   = sns[2*n +: 2];
      end
      w[12] = master;
      w[0]  = crit;
      return w;
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [31:0] w);
      wr_en   = 1'b1;
      wr_data = w;
      @(posedge clk);
      #1;
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   function automatic logic [3:0] stat();
      return rd_data[31:28];
   endfunction

   task automatic t_reset();
      chk("R1 rd_data", rd_data, 32'h0);
      chk("R1 irq_req", {28'h0, irq_req}, 32'h0);
      chk("R1 crit_route", {31'h0, crit_route}, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] w;
      w = mk(4'b1111, 1'b1, 8'b00_11_10_01, 4'b1111, 1'b1) | 32'hF000_E0FE;
      wr(w);
      chk("R2 readback", rd_data, w & 32'h00FF_1F01);
      chk("R3 clear bits zero", {28'h0, rd_data[27:24]}, 32'h0);
      chk("R12 crit_route", {31'h0, crit_route}, 32'h1);
      tick(3);
      chk("R5 level low on pin 0", {28'h0, irq_req}, 32'h4);
      wr(32'h0);
      chk("R12 crit_route cleared", {31'h0, crit_route}, 32'h0);
   endtask

   task automatic t_level();
      wr(mk(4'b1111, 1'b1, 8'h00, 4'h0, 1'b0));
      irq_pin = 4'b1010;
      tick(1);
      chk("R4 not after one edge", {28'h0, irq_req}, 32'h0);
      tick(1);
      chk("R4 after two edges", {28'h0, irq_req}, 32'ha);
      irq_pin = 4'b0000;
      tick(3);
      chk("R4 follows pin low", {28'h0, irq_req}, 32'h0);
      chk("R13 no latch in level mode", {28'h0, stat()}, 32'h0);
      wr(mk(4'b1111, 1'b1, 8'hff, 4'h0, 1'b0));
      irq_pin = 4'b0011;
      tick(3);
      chk("R5 level low", {28'h0, irq_req}, 32'hc);
      chk("R13 no latch in level low", {28'h0, stat()}, 32'h0);
      irq_pin = 4'b0000;
      tick(3);
   endtask

   task automatic t_rise();
      wr(mk(4'b1111, 1'b1, 8'h55, 4'h0, 1'b0));
      irq_pin = 4'b0001;
      tick(4);
      chk("R6 rising latched req", {28'h0, irq_req}, 32'h1);
      chk("R6 rising latched status", {28'h0, stat()}, 32'h1);
      irq_pin = 4'b0000;
      tick(4);
      chk("R6 sticky after fall", {28'h0, stat()}, 32'h1);
      chk("R6 req sticky after fall", {28'h0, irq_req}, 32'h1);
   endtask

   task automatic t_fall();
      wr(mk(4'b1111, 1'b1, 8'haa, 4'hf, 1'b0));
      chk("R8 clear all", {28'h0, stat()}, 32'h0);
      irq_pin = 4'b0011;
      tick(4);
      chk("R7 rise ignored in falling mode", {28'h0, stat()}, 32'h0);
      irq_pin = 4'b0000;
      tick(4);
      chk("R7 falling latched", {28'h0, stat()}, 32'h3);
   endtask

   task automatic t_clear();
      wr(mk(4'b1111, 1'b1, 8'haa, 4'b0001, 1'b0));
      chk("R8 clear line 0 only", {28'h0, stat()}, 32'h2);
      chk("R8 req after clear", {28'h0, irq_req}, 32'h2);
      wr(mk(4'b1111, 1'b1, 8'haa, 4'b0010, 1'b0));
      chk("R8 clear line 1", {28'h0, stat()}, 32'h0);
   endtask

   task automatic t_collide();
      wr(mk(4'b1111, 1'b1, 8'h55, 4'hf, 1'b0));
      irq_pin = 4'b0100;
      @(posedge clk);
      @(posedge clk);
      #1;
      wr(mk(4'b1111, 1'b1, 8'h55, 4'b0100, 1'b0));
      chk("R9 edge wins over clear", {28'h0, stat()}, 32'h4);
      tick(2);
      wr(mk(4'b1111, 1'b1, 8'h55, 4'b0100, 1'b0));
      chk("R8 isolated clear", {28'h0, stat()}, 32'h0);
      irq_pin = 4'b0000;
      tick(3);
   endtask

   task automatic t_gate();
      wr(mk(4'b0111, 1'b1, 8'h55, 4'hf, 1'b0));
      irq_pin = 4'b1000;
      tick(3);
      irq_pin = 4'b0000;
      tick(3);
      chk("R10 disabled req low", {28'h0, irq_req}, 32'h0);
      chk("R10 disabled still latches", {28'h0, stat()}, 32'h8);
      wr(mk(4'b1111, 1'b1, 8'h55, 4'h0, 1'b0));
      chk("R10 enabled req", {28'h0, irq_req}, 32'h8);
      wr(mk(4'b1111, 1'b0, 8'h55, 4'h0, 1'b1));
      chk("R11 master off", {28'h0, irq_req}, 32'h0);
      chk("R11 latch kept", {28'h0, stat()}, 32'h8);
      chk("R12 crit set", {31'h0, crit_route}, 32'h1);
   endtask

   initial begin
      #1_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_regs();
      t_level();
      t_rise();
      t_fall();
      t_clear();
      t_collide();
      t_gate();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule